// File: doc/BRIEF.md
# Row/Column Open-Buffer Tracker

This block keeps the open-buffer bookkeeping for a memory whose arrays can be opened either along a row or along a column. Every subarray of every bank holds at most one open buffer. The block records whether that buffer is open, whether it is a row or a column, which row or column index it holds, and which mux slice of it sits at the sense amplifiers. A scheduler uses it to ask, for a pending access, whether the access would hit the buffer that is already open.

Commands arrive on one port. Each command is a row activate, a column activate, a precharge or a no-op, and it carries a rank, a bank, a row and a column. The subarray is the row index divided by the subarray height. A lookup arrives on a second, independent port with the same address fields and an access direction. Its hit or miss answer appears one cycle later and is based on the state as it stood before any command in the same cycle. Within one bank, row buffers and column buffers are mutually exclusive. An activate that would break this rule is refused, leaves all state untouched and raises a one-cycle clash pulse.

Geometry defaults to 4 ranks, 8 banks per rank, 8192 rows, 1024 columns, 1024-row subarrays and 1024-wide row and column buffers. All of these are parameters.

Top module: `rcbuf_tracker`

## Requirements
- R1: After reset every subarray is closed: `clash_o` and `lk_done_o` are 0, and every lookup in either direction reports a miss.
- R2: A row activate (`cmd_op_i` = 0) opens, in subarray `row / SUB_ROWS`, the given row with mux slice `col / RB_SIZE`. A later row lookup (`lk_dir_i` = 0) with the same row and the same slice reports a hit.
- R3: A row lookup misses if the subarray is closed, if the open row differs, or if the stored slice differs from `col / RB_SIZE`.
- R4: A column activate (`cmd_op_i` = 1) opens the given column with mux slice `row / CB_SIZE`. A column lookup (`lk_dir_i` = 1) hits only if that subarray holds an open column with the same column index and the same slice.
- R5: A lookup whose direction differs from the direction of the open buffer always misses.
- R6: An activate of one direction, issued to a bank in which any subarray holds an open buffer of the other direction, raises `clash_o` for exactly the next cycle and changes no state. Other banks are unaffected, and no bank ever holds both kinds at once.
- R7: An activate in the same direction as an open buffer in the same subarray replaces that buffer without a clash.
- R8: A precharge (`cmd_op_i` = 2) closes only the addressed subarray and never clashes. Once a bank has no open buffer, an activate of either direction is accepted.
- R9: `lk_done_o` is high exactly in the cycle after `lk_valid_i`. The hit answer reflects the state before a command issued in the same cycle as the lookup.
- R10: Command code 3 has no effect on any state and raises no clash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 2 | 0 row activate, 1 column activate, 2 precharge, 3 no-op |
| cmd_rank_i | input | log2(RANKS) | Command rank |
| cmd_bank_i | input | log2(BANKS) | Command bank within rank |
| cmd_row_i | input | log2(ROWS) | Command row index |
| cmd_col_i | input | log2(COLS) | Command column index |
| lk_valid_i | input | 1 | Lookup present |
| lk_dir_i | input | 1 | Lookup direction: 0 row, 1 column |
| lk_rank_i | input | log2(RANKS) | Lookup rank |
| lk_bank_i | input | log2(BANKS) | Lookup bank within rank |
| lk_row_i | input | log2(ROWS) | Lookup row index |
| lk_col_i | input | log2(COLS) | Lookup column index |
| clash_o | output | 1 | One-cycle pulse: refused activate |
| lk_done_o | output | 1 | Lookup answer valid |
| lk_hit_o | output | 1 | Lookup hit (meaningful when lk_done_o is high) |

## Verification
A corrupted entry shows up on the lookup port, one cycle after a lookup addressed to that subarray. It appears as a false hit or a false miss, and the fault can surface only once a lookup touches the entry. A wrong direction flag or a stale active flag in a bank shows up even sooner as a wrong `clash_o` on the next opposite-direction activate, or as a missing one. The bench therefore sweeps every subarray of a reduced geometry and compares each cycle's `clash_o` and lookup answer against a model. This exposes a bad entry within one cycle of its first use.

// File: rtl/rcbuf_pkg.sv
package rcbuf_pkg;

    typedef enum logic [1:0] {
        OP_ACT_ROW = 2'd0,
        OP_ACT_COL = 2'd1,
        OP_PRE     = 2'd2,
        OP_NOP     = 2'd3
    } rcb_op_e;

    typedef enum logic {
        DIR_ROW = 1'b0,
        DIR_COL = 1'b1
    } rcb_dir_e;

    // Width of an index able to address n items (at least one bit).
    function automatic int unsigned bits_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rcbuf_decode.sv
module rcbuf_decode
    import rcbuf_pkg::*;
#(
    parameter int unsigned RANKS    = 4,
    parameter int unsigned BANKS    = 8,
    parameter int unsigned ROWS     = 8192,
    parameter int unsigned COLS     = 1024,
    parameter int unsigned SUB_ROWS = 1024,
    parameter int unsigned RB_SIZE  = 1024,
    parameter int unsigned CB_SIZE  = 1024,
    localparam int unsigned RANK_W  = bits_for(RANKS),
    localparam int unsigned BANK_W  = bits_for(BANKS),
    localparam int unsigned ROW_W   = bits_for(ROWS),
    localparam int unsigned COL_W   = bits_for(COLS),
    localparam int unsigned SUBS    = ROWS / SUB_ROWS,
    localparam int unsigned NSUB    = RANKS * BANKS * SUBS,
    localparam int unsigned IDX_W   = bits_for(NSUB),
    localparam int unsigned MUX_W   = max_of(bits_for(COLS / RB_SIZE), bits_for(ROWS / CB_SIZE))
) (
    input  logic [RANK_W-1:0] rank_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [COL_W-1:0]  col_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [MUX_W-1:0]  row_mux_o,
    output logic [MUX_W-1:0]  col_mux_o
);

    logic [31:0] sub_sel;
    logic [31:0] bank_flat;

    always_comb begin
        sub_sel   = 32'(row_i) / SUB_ROWS;
        bank_flat = 32'(rank_i) * BANKS + 32'(bank_i);
        idx_o     = IDX_W'(bank_flat * SUBS + sub_sel);
        // Row access: slice of the row buffer chosen by the column index.
        row_mux_o = MUX_W'(32'(col_i) / RB_SIZE);
        // Column access: slice of the column buffer chosen by the row index.
        col_mux_o = MUX_W'(32'(row_i) / CB_SIZE);
    end

endmodule

// File: rtl/rcbuf_state.sv
module rcbuf_state
    import rcbuf_pkg::*;
#(
    parameter int unsigned RANKS    = 4,
    parameter int unsigned BANKS    = 8,
    parameter int unsigned ROWS     = 8192,
    parameter int unsigned COLS     = 1024,
    parameter int unsigned SUB_ROWS = 1024,
    parameter int unsigned RB_SIZE  = 1024,
    parameter int unsigned CB_SIZE  = 1024,
    localparam int unsigned ROW_W   = bits_for(ROWS),
    localparam int unsigned COL_W   = bits_for(COLS),
    localparam int unsigned SUBS    = ROWS / SUB_ROWS,
    localparam int unsigned NBANK   = RANKS * BANKS,
    localparam int unsigned NSUB    = NBANK * SUBS,
    localparam int unsigned IDX_W   = bits_for(NSUB),
    localparam int unsigned BID_W   = bits_for(NBANK),
    localparam int unsigned KEY_W   = max_of(ROW_W, COL_W),
    localparam int unsigned MUX_W   = max_of(bits_for(COLS / RB_SIZE), bits_for(ROWS / CB_SIZE)),
    localparam int unsigned ENT_W   = 2 + KEY_W + MUX_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cmd_valid_i,
    input  rcb_op_e          cmd_op_i,
    input  logic [IDX_W-1:0] cmd_idx_i,
    input  logic [ROW_W-1:0] cmd_row_i,
    input  logic [COL_W-1:0] cmd_col_i,
    input  logic [MUX_W-1:0] cmd_row_mux_i,
    input  logic [MUX_W-1:0] cmd_col_mux_i,
    input  logic [IDX_W-1:0] lk_idx_i,
    output logic [ENT_W-1:0] lk_ent_o,
    output logic             clash_o
);

    typedef struct packed {
        logic             act;
        rcb_dir_e         dir;
        logic [KEY_W-1:0] key;
        logic [MUX_W-1:0] mux;
    } ent_t;

    ent_t             ent_q [NSUB];
    logic [NSUB-1:0]  act_vec;
    logic [NBANK-1:0] row_open;
    logic [NBANK-1:0] col_open;
    logic [BID_W-1:0] cmd_bank;
    logic             clash_now;
    logic             clash_q;

    // Per-bank summary of which buffer kind is currently open.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic ro;
        logic co;
        always_comb begin
            ro = 1'b0;
            co = 1'b0;
            for (int s = 0; s < SUBS; s++) begin
                if (ent_q[b * SUBS + s].act) begin
                    if (ent_q[b * SUBS + s].dir == DIR_ROW) ro = 1'b1;
                    else                                     co = 1'b1;
                end
            end
        end
        assign row_open[b] = ro;
        assign col_open[b] = co;

        AST_BANK_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (rst_i)
            !(row_open[b] && col_open[b])); // R6
    end

    for (genvar i = 0; i < NSUB; i++) begin : g_act
        assign act_vec[i] = ent_q[i].act;
    end

    always_comb begin
        cmd_bank  = BID_W'(32'(cmd_idx_i) / SUBS);
        clash_now = 1'b0;
        if (cmd_valid_i) begin
            unique case (cmd_op_i)
                OP_ACT_ROW: clash_now = col_open[cmd_bank];
                OP_ACT_COL: clash_now = row_open[cmd_bank];
                default:    clash_now = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < NSUB; i++) ent_q[i] <= '0;
            clash_q <= 1'b0;
        end else begin
            clash_q <= clash_now;
            if (cmd_valid_i && !clash_now) begin
                unique case (cmd_op_i)
                    OP_ACT_ROW: ent_q[cmd_idx_i] <= '{act: 1'b1, dir: DIR_ROW,
                                                      key: KEY_W'(cmd_row_i),
                                                      mux: cmd_row_mux_i};
                    OP_ACT_COL: ent_q[cmd_idx_i] <= '{act: 1'b1, dir: DIR_COL,
                                                      key: KEY_W'(cmd_col_i),
                                                      mux: cmd_col_mux_i};
                    OP_PRE:     ent_q[cmd_idx_i].act <= 1'b0;
                    default:    ;
                endcase
            end
        end
    end

    assign lk_ent_o = ent_q[lk_idx_i];
    assign clash_o  = clash_q;

    AST_CLASH_FREEZES: assert property (@(posedge clk_i) disable iff (rst_i)
        clash_now |=> $stable(act_vec)); // R6

    AST_CLASH_FROM_ACT: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(clash_o) |-> $past(cmd_valid_i && (cmd_op_i == OP_ACT_ROW || cmd_op_i == OP_ACT_COL))); // R6

    AST_PRE_CLOSES: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_valid_i && cmd_op_i == OP_PRE && 32'(cmd_idx_i) < NSUB) |=> !act_vec[$past(cmd_idx_i)]); // R8

    AST_NOP_FREEZES: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_valid_i && cmd_op_i == OP_NOP) |=> ($stable(act_vec) && !clash_o)); // R10

endmodule

// File: rtl/rcbuf_lookup.sv
module rcbuf_lookup
    import rcbuf_pkg::*;
#(
    parameter int unsigned ROW_W = 13,
    parameter int unsigned COL_W = 10,
    parameter int unsigned MUX_W = 3,
    localparam int unsigned KEY_W = max_of(ROW_W, COL_W),
    localparam int unsigned ENT_W = 2 + KEY_W + MUX_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             lk_valid_i,
    input  rcb_dir_e         lk_dir_i,
    input  logic [ROW_W-1:0] lk_row_i,
    input  logic [COL_W-1:0] lk_col_i,
    input  logic [MUX_W-1:0] lk_row_mux_i,
    input  logic [MUX_W-1:0] lk_col_mux_i,
    input  logic [ENT_W-1:0] ent_i,
    output logic             done_o,
    output logic             hit_o
);

    typedef struct packed {
        logic             act;
        rcb_dir_e         dir;
        logic [KEY_W-1:0] key;
        logic [MUX_W-1:0] mux;
    } ent_t;

    ent_t e;
    logic hit_now;
    logic done_q;
    logic hit_q;

    always_comb begin
        e = ent_t'(ent_i);
        if (lk_dir_i == DIR_ROW) begin
            hit_now = e.act && (e.dir == DIR_ROW)
                   && (e.key == KEY_W'(lk_row_i)) && (e.mux == lk_row_mux_i);
        end else begin
            hit_now = e.act && (e.dir == DIR_COL)
                   && (e.key == KEY_W'(lk_col_i)) && (e.mux == lk_col_mux_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            done_q <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            done_q <= lk_valid_i;
            hit_q  <= lk_valid_i && hit_now;
        end
    end

    assign done_o = done_q;
    assign hit_o  = hit_q;

    AST_DONE_AFTER_LK: assert property (@(posedge clk_i) disable iff (rst_i)
        lk_valid_i |=> done_o); // R9

    AST_IDLE_NO_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        !lk_valid_i |=> !done_o); // R9

    AST_HIT_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |-> done_o); // R9

endmodule

// File: rtl/rcbuf_tracker.sv
module rcbuf_tracker
    import rcbuf_pkg::*;
#(
    parameter int unsigned RANKS    = 4,
    parameter int unsigned BANKS    = 8,
    parameter int unsigned ROWS     = 8192,
    parameter int unsigned COLS     = 1024,
    parameter int unsigned SUB_ROWS = 1024,
    parameter int unsigned RB_SIZE  = 1024,
    parameter int unsigned CB_SIZE  = 1024,
    localparam int unsigned RANK_W  = bits_for(RANKS),
    localparam int unsigned BANK_W  = bits_for(BANKS),
    localparam int unsigned ROW_W   = bits_for(ROWS),
    localparam int unsigned COL_W   = bits_for(COLS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cmd_valid_i,
    input  logic [1:0]        cmd_op_i,
    input  logic [RANK_W-1:0] cmd_rank_i,
    input  logic [BANK_W-1:0] cmd_bank_i,
    input  logic [ROW_W-1:0]  cmd_row_i,
    input  logic [COL_W-1:0]  cmd_col_i,
    input  logic              lk_valid_i,
    input  logic              lk_dir_i,
    input  logic [RANK_W-1:0] lk_rank_i,
    input  logic [BANK_W-1:0] lk_bank_i,
    input  logic [ROW_W-1:0]  lk_row_i,
    input  logic [COL_W-1:0]  lk_col_i,
    output logic              clash_o,
    output logic              lk_done_o,
    output logic              lk_hit_o
);

    localparam int unsigned SUBS  = ROWS / SUB_ROWS;
    localparam int unsigned NSUB  = RANKS * BANKS * SUBS;
    localparam int unsigned IDX_W = bits_for(NSUB);
    localparam int unsigned KEY_W = max_of(ROW_W, COL_W);
    localparam int unsigned MUX_W = max_of(bits_for(COLS / RB_SIZE), bits_for(ROWS / CB_SIZE));
    localparam int unsigned ENT_W = 2 + KEY_W + MUX_W;

    logic [IDX_W-1:0] cmd_idx;
    logic [MUX_W-1:0] cmd_row_mux;
    logic [MUX_W-1:0] cmd_col_mux;
    logic [IDX_W-1:0] lk_idx;
    logic [MUX_W-1:0] lk_row_mux;
    logic [MUX_W-1:0] lk_col_mux;
    logic [ENT_W-1:0] lk_ent;
    rcb_op_e          cmd_op;
    rcb_dir_e         lk_dir;

    assign cmd_op = rcb_op_e'(cmd_op_i);
    assign lk_dir = rcb_dir_e'(lk_dir_i);

    rcbuf_decode #(
        .RANKS(RANKS), .BANKS(BANKS), .ROWS(ROWS), .COLS(COLS),
        .SUB_ROWS(SUB_ROWS), .RB_SIZE(RB_SIZE), .CB_SIZE(CB_SIZE)
    ) cmd_dec_i (
        .rank_i    (cmd_rank_i),
        .bank_i    (cmd_bank_i),
        .row_i     (cmd_row_i),
        .col_i     (cmd_col_i),
        .idx_o     (cmd_idx),
        .row_mux_o (cmd_row_mux),
        .col_mux_o (cmd_col_mux)
    );

    rcbuf_decode #(
        .RANKS(RANKS), .BANKS(BANKS), .ROWS(ROWS), .COLS(COLS),
        .SUB_ROWS(SUB_ROWS), .RB_SIZE(RB_SIZE), .CB_SIZE(CB_SIZE)
    ) lk_dec_i (
        .rank_i    (lk_rank_i),
        .bank_i    (lk_bank_i),
        .row_i     (lk_row_i),
        .col_i     (lk_col_i),
        .idx_o     (lk_idx),
        .row_mux_o (lk_row_mux),
        .col_mux_o (lk_col_mux)
    );

    rcbuf_state #(
        .RANKS(RANKS), .BANKS(BANKS), .ROWS(ROWS), .COLS(COLS),
        .SUB_ROWS(SUB_ROWS), .RB_SIZE(RB_SIZE), .CB_SIZE(CB_SIZE)
    ) state_i (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .cmd_valid_i   (cmd_valid_i),
        .cmd_op_i      (cmd_op),
        .cmd_idx_i     (cmd_idx),
        .cmd_row_i     (cmd_row_i),
        .cmd_col_i     (cmd_col_i),
        .cmd_row_mux_i (cmd_row_mux),
        .cmd_col_mux_i (cmd_col_mux),
        .lk_idx_i      (lk_idx),
        .lk_ent_o      (lk_ent),
        .clash_o       (clash_o)
    );

    rcbuf_lookup #(
        .ROW_W(ROW_W), .COL_W(COL_W), .MUX_W(MUX_W)
    ) lookup_i (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .lk_valid_i   (lk_valid_i),
        .lk_dir_i     (lk_dir),
        .lk_row_i     (lk_row_i),
        .lk_col_i     (lk_col_i),
        .lk_row_mux_i (lk_row_mux),
        .lk_col_mux_i (lk_col_mux),
        .ent_i        (lk_ent),
        .done_o       (lk_done_o),
        .hit_o        (lk_hit_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (!clash_o && !lk_done_o && !lk_hit_o)); // R1

endmodule

// File: tb/rcbuf_tracker_tb_top.sv
`timescale 1ns/1ps
module rcbuf_tracker_tb_top;

    localparam int RK  = 2;
    localparam int BK  = 2;
    localparam int RW  = 64;
    localparam int CL  = 32;
    localparam int SR  = 16;
    localparam int RBS = 8;
    localparam int CBS = 8;
    localparam int NS  = RW / SR;
    localparam int N   = RK * BK * NS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd3;
    logic       cmd_rank = 1'b0;
    logic       cmd_bank = 1'b0;
    logic [5:0] cmd_row = '0;
    logic [4:0] cmd_col = '0;
    logic       lk_valid = 1'b0;
    logic       lk_dir = 1'b0;
    logic       lk_rank = 1'b0;
    logic       lk_bank = 1'b0;
    logic [5:0] lk_row = '0;
    logic [4:0] lk_col = '0;
    logic       clash;
    logic       lk_done;
    logic       lk_hit;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    bit  m_act [N];
    bit  m_dir [N];
    int  m_key [N];
    int  m_mux [N];

    always #2 clk = ~clk;

    rcbuf_tracker #(
        .RANKS(RK), .BANKS(BK), .ROWS(RW), .COLS(CL),
        .SUB_ROWS(SR), .RB_SIZE(RBS), .CB_SIZE(CBS)
    ) dut_i (
        .clk_i(clk), .rst_i(rst),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
        .cmd_rank_i(cmd_rank), .cmd_bank_i(cmd_bank),
        .cmd_row_i(cmd_row), .cmd_col_i(cmd_col),
        .lk_valid_i(lk_valid), .lk_dir_i(lk_dir),
        .lk_rank_i(lk_rank), .lk_bank_i(lk_bank),
        .lk_row_i(lk_row), .lk_col_i(lk_col),
        .clash_o(clash), .lk_done_o(lk_done), .lk_hit_o(lk_hit)
    );

    function automatic int fidx(int rk, int bk, int row);
        return (rk * BK + bk) * NS + row / SR;
    endfunction

    function automatic bit bank_has(int rk, int bk, bit dir);
        for (int s = 0; s < NS; s++) begin
            int i = (rk * BK + bk) * NS + s;
            if (m_act[i] && m_dir[i] == dir) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_act[i] = 1'b0; m_dir[i] = 1'b0; m_key[i] = 0; m_mux[i] = 0;
        end
    endtask

    // Entered at a falling edge; returns at the next falling edge.
    task automatic step(bit cv, int op, int rk, int bk, int row, int col,
                        bit lv, int ld, int lrk, int lbk, int lrow, int lcol,
                        string ctag, string ltag);
        bit exp_clash;
        bit exp_hit;
        int li;
        int ci;
        exp_clash = cv && ((op == 0 && bank_has(rk, bk, 1'b1)) ||
                           (op == 1 && bank_has(rk, bk, 1'b0)));
        li = fidx(lrk, lbk, lrow);
        exp_hit = lv && m_act[li] && (m_dir[li] == ld[0]) &&
                  ((ld == 0) ? (m_key[li] == lrow && m_mux[li] == lcol / RBS)
                             : (m_key[li] == lcol && m_mux[li] == lrow / CBS));
        cmd_valid = cv;       cmd_op  = 2'(op);
        cmd_rank  = 1'(rk);   cmd_bank = 1'(bk);
        cmd_row   = 6'(row);  cmd_col  = 5'(col);
        lk_valid  = lv;       lk_dir   = ld[0];
        lk_rank   = 1'(lrk);  lk_bank  = 1'(lbk);
        lk_row    = 6'(lrow); lk_col   = 5'(lcol);
        @(posedge clk);
        @(negedge clk);
        chk(clash == exp_clash, ctag, "clash", int'(clash), int'(exp_clash));
        chk(lk_done == lv, ltag, "done", int'(lk_done), int'(lv));
        if (lv) chk(lk_hit == exp_hit, ltag, "hit", int'(lk_hit), int'(exp_hit));
        if (cv && !exp_clash) begin
            ci = fidx(rk, bk, row);
            if (op == 0) begin
                m_act[ci] = 1'b1; m_dir[ci] = 1'b0; m_key[ci] = row; m_mux[ci] = col / RBS;
            end else if (op == 1) begin
                m_act[ci] = 1'b1; m_dir[ci] = 1'b1; m_key[ci] = col; m_mux[ci] = row / CBS;
            end else if (op == 2) begin
                m_act[ci] = 1'b0;
            end
        end
        cmd_valid = 1'b0;
        lk_valid  = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cmd_valid = 1'b0;
        lk_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk(clash == 1'b0, "R1", "clash after reset", int'(clash), 0);
        chk(lk_done == 1'b0, "R1", "done after reset", int'(lk_done), 0);
    endtask

    task automatic sweep_all_miss();
        for (int rk = 0; rk < RK; rk++)
            for (int bk = 0; bk < BK; bk++)
                for (int row = 0; row < RW; row += 4)
                    for (int d = 0; d < 2; d++)
                        step(0, 3, 0, 0, 0, 0, 1, d, rk, bk, row, row % CL, "R1", "R1");
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();
        sweep_all_miss();

        // R2 / R3: row open and its hit conditions
        step(1, 0, 0, 0, 5, 9, 0, 0, 0, 0, 0, 0, "R2", "R2");
        for (int c = 8; c < 16; c++)
            step(0, 3, 0, 0, 0, 0, 1, 0, 0, 0, 5, c, "R2", "R2");
        step(0, 3, 0, 0, 0, 0, 1, 0, 0, 0, 5, 0, "R3", "R3");
        step(0, 3, 0, 0, 0, 0, 1, 0, 0, 0, 6, 9, "R3", "R3");
        step(0, 3, 0, 0, 0, 0, 1, 0, 0, 0, 21, 9, "R3", "R3");
        step(0, 3, 0, 0, 0, 0, 1, 0, 1, 0, 5, 9, "R3", "R3");
        // R5: opposite-direction lookup on the open row
        step(0, 3, 0, 0, 0, 0, 1, 1, 0, 0, 5, 5, "R5", "R5");
        step(0, 3, 0, 0, 0, 0, 1, 1, 0, 0, 5, 9, "R5", "R5");
        // R6: column activate on a bank holding a row is refused
        step(1, 1, 0, 0, 40, 3, 0, 0, 0, 0, 0, 0, "R6", "R6");
        step(0, 3, 0, 0, 0, 0, 1, 1, 0, 0, 40, 3, "R6", "R6");
        step(0, 3, 0, 0, 0, 0, 1, 0, 0, 0, 5, 9, "R6", "R6");
        // R4 / R6: another bank accepts a column
        step(1, 1, 0, 1, 40, 3, 0, 0, 0, 0, 0, 0, "R6", "R6");
        step(0, 3, 0, 0, 0, 0, 1, 1, 0, 1, 40, 3, "R4", "R4");
        step(0, 3, 0, 0, 0, 0, 1, 1, 0, 1, 47, 3, "R4", "R4");
        step(0, 3, 0, 0, 0, 0, 1, 1, 0, 1, 33, 3, "R4", "R4");
        step(0, 3, 0, 0, 0, 0, 1, 1, 0, 1, 40, 4, "R4", "R4");
        step(0, 3, 0, 0, 0, 0, 1, 0, 0, 1, 40, 3, "R5", "R5");
        step(1, 0, 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R6", "R6");
        // R7: same-direction replace
        step(1, 0, 0, 0, 7, 20, 0, 0, 0, 0, 0, 0, "R7", "R7");
        step(0, 3, 0, 0, 0, 0, 1, 0, 0, 0, 5, 9, "R7", "R7");
        step(0, 3, 0, 0, 0, 0, 1, 0, 0, 0, 7, 20, "R7", "R7");
        // R9: lookup sees state before same-cycle precharge
        step(1, 2, 0, 0, 7, 0, 1, 0, 0, 0, 7, 20, "R9", "R9");
        step(0, 3, 0, 0, 0, 0, 1, 0, 0, 0, 7, 20, "R8", "R8");
        // R8: precharge one subarray only, then exclusivity released
        step(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8", "R8");
        step(1, 0, 1, 0, 16, 0, 0, 0, 0, 0, 0, 0, "R8", "R8");
        step(1, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8", "R8");
        step(0, 3, 0, 0, 0, 0, 1, 0, 1, 0, 16, 0, "R8", "R8");
        step(0, 3, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, "R8", "R8");
        step(1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R8", "R8");
        step(0, 3, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R8", "R8");
        // R10: no-op changes nothing
        step(1, 3, 1, 0, 16, 0, 0, 0, 0, 0, 0, 0, "R10", "R10");
        step(0, 3, 0, 0, 0, 0, 1, 0, 1, 0, 16, 0, "R10", "R10");
        step(1, 3, 0, 0, 0, 1, 1, 1, 0, 0, 0, 1, "R10", "R10");
        step(0, 3, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, "R10", "R10");

        // Mixed traffic against the model
        begin
            logic [31:0] seed = 32'h1234_5678;
            int lrk = 0, lbk = 0, lrow = 0, lcol = 0, ldr = 0;
            for (int k = 0; k < 4000; k++) begin
                int op, rk, bk, row, col, ld, qrk, qbk, qrow, qcol;
                bit cv, lv;
                seed = seed * 32'd1664525 + 32'd1013904223;
                cv  = seed[31];
                op  = int'(seed[30:29]);
                rk  = int'(seed[28]);
                bk  = int'(seed[27]);
                row = int'(seed[26:21]);
                col = int'(seed[20:16]);
                lv  = seed[15];
                if (seed[14]) begin
                    qrk = lrk; qbk = lbk; qrow = lrow; qcol = lcol; ld = ldr;
                    if (seed[13]) ld = 1 - ldr;
                end else begin
                    qrk = int'(seed[12]); qbk = int'(seed[11]);
                    qrow = int'(seed[10:5]); qcol = int'(seed[4:0]);
                    ld = int'(seed[13]);
                end
                if (cv && op < 2) begin
                    lrk = rk; lbk = bk; lrow = row; lcol = col; ldr = op;
                end
                step(cv, op, rk, bk, row, col, lv, ld, qrk, qbk, qrow, qcol,
                     "R6", (ld == 0) ? "R3" : "R4");
            end
        end

        // Reset mid-run closes everything again
        do_reset();
        sweep_all_miss();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule